// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval counter. Its 16-bit counter runs down once for each pulse on a count strobe. The strobe is sampled on the system clock, so one strobe pulse is one count clock. A host sets the channel up through an 8-bit bus. A write to the control address carries a control word. Writes and reads at the data address carry count bytes.

The control word sets four things: whether the channel should listen at all, how count bytes are sequenced over the byte-wide port, the waveform, and whether the count runs in binary or in four decimal digits. There are two waveforms:

- A one-shot output that rises once after a programmed number of counts.
- A free-running square wave whose period equals the loaded count.

A gate input can pause the channel or restart it. A latch command freezes a copy of the count, so software can read both bytes of the count at a single instant while counting continues.

Top module: `ivl_counter_chan`

## Requirements
- R1: After synchronous reset the output is high, the count reads 0000h, and the channel uses low-then-high byte order, one-shot mode and binary counting.
- R2: Control word fields: bits 7:6 are the channel select, bits 5:4 the access code, bits 3:1 the mode, and bit 0 the decimal flag. Mode 011 gives the square wave and every other mode value gives the one-shot. The channel ignores a control word whose select differs from parameter CHAN_ID (default 0).
- R3: With access code 11, data writes and data reads each alternate low byte then high byte. A control word returns both byte pointers to the low byte.
- R4: Access code 01 moves only the low byte and loads the high byte as zero. Access code 10 moves only the high byte and loads the low byte as zero.
- R5: In one-shot mode, completing a count load drives the output low. After N count strobes the output goes high, and it stays high until the next load.
- R6: In one-shot mode, count strobes that arrive while the gate is low leave the count unchanged.
- R7: In one-shot mode, a new count load restarts the sequence from the new value.
- R8: In square-wave mode with even N, the output is high for N/2 strobes and low for N/2 strobes, and the count reloads by itself with no gap.
- R9: In square-wave mode with odd N, the output is high for (N+1)/2 strobes and low for (N-1)/2 strobes.
- R10: In square-wave mode, a low gate forces the output high and returns the count to its loaded value. Counting resumes from that value once the gate is high again.
- R11: Access code 00 in a control word is a latch command. Reads then return the frozen count until every byte of the current access code has been read, while the live count keeps moving. A second latch command that arrives before those reads is ignored.
- R12: A loaded count of zero lasts 65536 strobes in binary and 10000 strobes in decimal. The first strobe turns it into FFFFh or 9999 respectively.
- R13: In decimal mode each 4-bit digit counts down 9 to 0 and borrows from the digit above it. The square wave then has a period of the decimal value N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe for one clock; moves the read pointer at the data address |
| bus_ctrl | input | 1 | 1 selects the control address, 0 the data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Count byte currently addressed for reading |
| cnt_strobe | input | 1 | Count clock, one pulse per count |
| gate | input | 1 | Gate: pauses in one-shot mode, holds and restarts in square-wave mode |
| wave_out | output | 1 | Counter output |

## Verification
The properties take some things for granted about the host:

- It does not put a latch command and a data read in the same clock.
- In decimal mode it loads only valid decimal digits.
- It never loads the value 1 for a square wave.

The stimulus respects all of these. Every decimal load is written as legal digits, square-wave sweeps start at N=2, and reads are always issued as separate bus cycles after any control write.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int DIGITS   = CNT_W / 4;
    localparam int MAG_W    = CNT_W + 1;
    localparam int BIN_SPAN = 1 << CNT_W;
    localparam int BCD_SPAN = 10 ** DIGITS;
    localparam int SEL_LSB  = 6;
    localparam int RW_LSB   = 4;
    localparam int MODE_LSB = 1;
    localparam logic [2:0] SQUARE_CODE = 3'b011;

    typedef enum logic [1:0] {
        RW_LATCH = 2'b00,
        RW_LO    = 2'b01,
        RW_HI    = 2'b10,
        RW_LOHI  = 2'b11
    } rw_e;

    typedef enum logic {
        MD_TERM   = 1'b0,
        MD_SQUARE = 1'b1
    } mode_e;

    typedef struct packed {
        rw_e   rw;
        mode_e mode;
        logic  bcd;
    } cfg_t;

    // one step down; decimal digits borrow from the digit above
    function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        r = v;
        borrow = 1'b1;
        if (!bcd) begin
            r = v - CNT_W'(1);
        end else begin
            for (int i = 0; i < DIGITS; i++) begin
                if (borrow) begin
                    if (v[4*i +: 4] == 4'd0) begin
                        r[4*i +: 4] = 4'd9;
                    end else begin
                        r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                        borrow = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    // number of counts a value stands for; zero is the full span
    function automatic logic [MAG_W-1:0] cnt_mag(input logic [CNT_W-1:0] v, input logic bcd);
        logic [MAG_W-1:0] acc;
        acc = '0;
        if (v == '0) begin
            acc = bcd ? MAG_W'(BCD_SPAN) : MAG_W'(BIN_SPAN);
        end else if (!bcd) begin
            acc = {1'b0, v};
        end else begin
            for (int i = DIGITS - 1; i >= 0; i--) begin
                acc = acc * MAG_W'(10) + MAG_W'(v[4*i +: 4]);
            end
        end
        return acc;
    endfunction
endpackage

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
    import ivl_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              is_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              cfg_wr,
    output logic              latch_cmd,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val
);
    logic              word_hit;
    logic              data_wr;
    logic              ptr_hi;
    logic [BYTE_W-1:0] lo_hold;

    assign word_hit  = wr_en && is_ctrl && (wr_data[SEL_LSB +: 2] == CHAN_ID);
    assign latch_cmd = word_hit && (wr_data[RW_LSB +: 2] == RW_LATCH);
    assign cfg_wr    = word_hit && (wr_data[RW_LSB +: 2] != RW_LATCH);
    assign data_wr   = wr_en && !is_ctrl;

    always_comb begin
        load_stb = 1'b0;
        load_val = '0;
        case (cfg.rw)
            RW_LO: begin
                load_stb = data_wr;
                load_val = {{BYTE_W{1'b0}}, wr_data};
            end
            RW_HI: begin
                load_stb = data_wr;
                load_val = {wr_data, {BYTE_W{1'b0}}};
            end
            RW_LOHI: begin
                load_stb = data_wr && ptr_hi;
                load_val = {wr_data, lo_hold};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{rw: RW_LOHI, mode: MD_TERM, bcd: 1'b0};
            ptr_hi  <= 1'b0;
            lo_hold <= '0;
        end else if (cfg_wr) begin
            cfg.rw   <= rw_e'(wr_data[RW_LSB +: 2]);
            cfg.mode <= (wr_data[MODE_LSB +: 3] == SQUARE_CODE) ? MD_SQUARE : MD_TERM;
            cfg.bcd  <= wr_data[0];
            ptr_hi   <= 1'b0;
        end else if (data_wr && (cfg.rw == RW_LOHI)) begin
            if (!ptr_hi) begin
                lo_hold <= wr_data;
            end
            ptr_hi <= !ptr_hi;
        end
    end
endmodule

// File: rtl/ivl_core.sv
module ivl_core
    import ivl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             bcd,
    input  logic             cfg_wr,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             gate,
    output logic [CNT_W-1:0] count,
    output logic             wave
);
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] sq_next;
    logic [MAG_W-1:0] half;
    logic             armed;

    assign dec_val = cnt_dec(count, bcd);
    assign sq_next = (count == CNT_W'(1)) ? reload : dec_val;
    assign half    = cnt_mag(reload, bcd) >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
            armed  <= 1'b0;
            wave   <= 1'b1;
        end else if (cfg_wr) begin
            armed <= 1'b0;
            wave  <= 1'b1;
        end else if (load_stb) begin
            count  <= load_val;
            reload <= load_val;
            armed  <= 1'b1;
            wave   <= (mode == MD_SQUARE);
        end else if (armed) begin
            if (mode == MD_SQUARE) begin
                if (!gate) begin
                    wave  <= 1'b1;
                    count <= reload;
                end else if (tick) begin
                    count <= sq_next;
                    wave  <= (cnt_mag(sq_next, bcd) > half);
                end
            end else if (gate && tick) begin
                count <= dec_val;
                if (dec_val == '0) begin
                    wave <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ivl_readout.sv
module ivl_readout
    import ivl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rw_e               rw,
    input  logic              cfg_wr,
    input  logic              latch_cmd,
    input  logic              rd_fire,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rd_data,
    output logic              latched
);
    logic [CNT_W-1:0] snap;
    logic [CNT_W-1:0] src;
    logic             ptr_hi;
    logic             last_byte;

    assign src       = latched ? snap : count;
    assign last_byte = (rw != RW_LOHI) || ptr_hi;

    always_comb begin
        case (rw)
            RW_HI:   rd_data = src[CNT_W-1 -: BYTE_W];
            RW_LOHI: rd_data = ptr_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
            default: rd_data = src[BYTE_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap    <= '0;
            latched <= 1'b0;
            ptr_hi  <= 1'b0;
        end else if (cfg_wr) begin
            latched <= 1'b0;
            ptr_hi  <= 1'b0;
        end else if (latch_cmd) begin
            if (!latched) begin
                snap    <= count;
                latched <= 1'b1;
            end
        end else if (rd_fire) begin
            if (rw == RW_LOHI) begin
                ptr_hi <= !ptr_hi;
            end
            if (last_byte) begin
                latched <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ivl_counter_chan.sv
module ivl_counter_chan
    import ivl_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_ctrl,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_strobe,
    input  logic              gate,
    output logic              wave_out
);
    cfg_t             cfg;
    logic             cfg_wr;
    logic             latch_cmd;
    logic             load_stb;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             rd_fire;
    logic             latched;

    assign rd_fire = bus_rd && !bus_ctrl;

    ivl_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .is_ctrl   (bus_ctrl),
        .wr_data   (bus_wdata),
        .cfg       (cfg),
        .cfg_wr    (cfg_wr),
        .latch_cmd (latch_cmd),
        .load_stb  (load_stb),
        .load_val  (load_val)
    );

    ivl_core u_core (
        .clk      (clk),
        .rst      (rst),
        .mode     (cfg.mode),
        .bcd      (cfg.bcd),
        .cfg_wr   (cfg_wr),
        .load_stb (load_stb),
        .load_val (load_val),
        .tick     (cnt_strobe),
        .gate     (gate),
        .count    (count),
        .wave     (wave_out)
    );

    ivl_readout u_readout (
        .clk       (clk),
        .rst       (rst),
        .rw        (cfg.rw),
        .cfg_wr    (cfg_wr),
        .latch_cmd (latch_cmd),
        .rd_fire   (rd_fire),
        .count     (count),
        .rd_data   (bus_rdata),
        .latched   (latched)
    );
endmodule

// File: rtl/ivl_counter_chan_chk.sv
module ivl_counter_chan_chk
    import ivl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_ctrl,
    input logic              bus_rd,
    input logic [1:0]        sel_field,
    input logic [1:0]        chan_id,
    input logic              gate,
    input logic              cnt_strobe,
    input logic              wave_out,
    input cfg_t              cfg,
    input logic              cfg_wr,
    input logic              load_stb,
    input logic [CNT_W-1:0]  count,
    input logic              latched,
    input logic [BYTE_W-1:0] bus_rdata
);
    // R2: a control word for another channel leaves the configuration alone
    a_r2_foreign_word_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ctrl && (sel_field != chan_id)) |=> $stable(cfg));

    // R5: a completed load in one-shot mode pulls the output low
    a_r5_load_drops_output: assert property (@(posedge clk) disable iff (rst)
        (load_stb && (cfg.mode == MD_TERM)) |=> !wave_out);

    // R5: once high in one-shot mode, the output holds until a load or a new word
    a_r5_terminal_sticky: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MD_TERM) && wave_out && !load_stb && !cfg_wr) |=> wave_out);

    // R6: a low gate freezes the one-shot count
    a_r6_gate_freezes: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MD_TERM) && !gate && !load_stb) |=> $stable(count));

    // R8: the square wave changes only on a count strobe
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MD_SQUARE) && gate && !cnt_strobe && !load_stb && !cfg_wr)
        |=> $stable(wave_out));

    // R10: a low gate holds the square wave high
    a_r10_gate_forces_high: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MD_SQUARE) && !gate && !load_stb) |=> wave_out);

    // R11: the frozen value on the read port holds until it is read
    a_r11_snapshot_holds: assert property (@(posedge clk) disable iff (rst)
        (latched && !bus_rd && !cfg_wr) |=> $stable(bus_rdata));
endmodule

bind ivl_counter_chan ivl_counter_chan_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_ctrl   (bus_ctrl),
    .bus_rd     (bus_rd),
    .sel_field  (bus_wdata[7:6]),
    .chan_id    (CHAN_ID),
    .gate       (gate),
    .cnt_strobe (cnt_strobe),
    .wave_out   (wave_out),
    .cfg        (cfg),
    .cfg_wr     (cfg_wr),
    .load_stb   (load_stb),
    .count      (count),
    .latched    (latched),
    .bus_rdata  (bus_rdata)
);

// File: tb/ivl_counter_chan_bench.sv
module ivl_counter_chan_bench;
    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk        = 1'b0;
    logic       rst        = 1'b1;
    logic       bus_wr     = 1'b0;
    logic       bus_rd     = 1'b0;
    logic       bus_ctrl   = 1'b0;
    logic [7:0] bus_wdata  = 8'h00;
    logic       cnt_strobe = 1'b0;
    logic       gate       = 1'b1;
    logic [7:0] bus_rdata;
    logic       wave_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivl_counter_chan u_ivl_counter_chan (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_ctrl   (bus_ctrl),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_strobe (cnt_strobe),
        .gate       (gate),
        .wave_out   (wave_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_ctrl(input logic [7:0] w);
        bus_wr = 1'b1; bus_ctrl = 1'b1; bus_wdata = w;
        @(negedge clk);
        bus_wr = 1'b0; bus_ctrl = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] w);
        bus_wr = 1'b1; bus_ctrl = 1'b0; bus_wdata = w;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic load16(input logic [7:0] ctrl, input logic [15:0] v);
        put_ctrl(ctrl);
        put_data(v[7:0]);
        put_data(v[15:8]);
    endtask

    task automatic get_byte(output logic [7:0] b);
        bus_rd = 1'b1;
        #1;
        b = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo;
        logic [7:0] hi;
        get_byte(lo);
        get_byte(hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            cnt_strobe = 1'b1;
            repeat (n) @(negedge clk);
            cnt_strobe = 1'b0;
        end
    endtask

    // square wave sweep: after k strobes the count is N - (k mod N)
    task automatic sweep_square(input string tag, input int n);
        int c;
        for (int k = 0; k < 3 * n; k++) begin
            c = n - (k % n);
            check(tag, {31'd0, wave_out}, {31'd0, (c > n / 2)});
            ticks(1);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        logic [7:0]  b2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 output after reset", {31'd0, wave_out}, 32'd1);
        read16(v);
        check("R1 count after reset", {16'd0, v}, 32'h0000);

        // R2: a word for channel 1 is ignored
        load16(8'h30, 16'h1234);
        put_ctrl(8'h50);
        check("R2 output kept low", {31'd0, wave_out}, 32'd0);
        read16(v);
        check("R2 byte order kept", {16'd0, v}, 32'h1234);

        // R3: a control word resets the write pointer
        put_ctrl(8'h30);
        put_data(8'hAA);
        load16(8'h30, 16'h0007);
        read16(v);
        check("R3 pointer reset", {16'd0, v}, 32'h0007);

        // R4: single-byte access codes
        put_ctrl(8'h10);
        put_data(8'h09);
        get_byte(b);
        check("R4 low-only load", {24'd0, b}, 32'h09);
        check("R4 output low after load", {31'd0, wave_out}, 32'd0);
        put_ctrl(8'h20);
        put_data(8'h03);
        get_byte(b);
        check("R4 high-only load", {24'd0, b}, 32'h03);
        put_ctrl(8'h30);
        read16(v);
        check("R4 low byte zeroed", {16'd0, v}, 32'h0300);

        // R5: one-shot sweep over N
        for (int n = 1; n <= 12; n++) begin
            load16(8'h30, 16'(n));
            check("R5 low on load", {31'd0, wave_out}, 32'd0);
            ticks(n - 1);
            check("R5 low before terminal", {31'd0, wave_out}, 32'd0);
            ticks(1);
            check("R5 high at terminal", {31'd0, wave_out}, 32'd1);
            ticks(3);
            check("R5 stays high", {31'd0, wave_out}, 32'd1);
        end

        // R6: gate pauses one-shot counting
        load16(8'h30, 16'd10);
        ticks(4);
        gate = 1'b0;
        ticks(20);
        check("R6 output while paused", {31'd0, wave_out}, 32'd0);
        read16(v);
        check("R6 count frozen", {16'd0, v}, 32'd6);
        gate = 1'b1;
        ticks(5);
        check("R6 low before resumed end", {31'd0, wave_out}, 32'd0);
        ticks(1);
        check("R6 high after resumed end", {31'd0, wave_out}, 32'd1);

        // R7: reload restarts the sequence
        load16(8'h30, 16'd8);
        ticks(5);
        put_data(8'd8);
        put_data(8'd0);
        ticks(7);
        check("R7 restarted count low", {31'd0, wave_out}, 32'd0);
        ticks(1);
        check("R7 restarted count high", {31'd0, wave_out}, 32'd1);
        put_data(8'd3);
        put_data(8'd0);
        check("R7 reload after terminal", {31'd0, wave_out}, 32'd0);

        // R8 / R9: square wave sweeps (36h: channel 0, low-high, square, binary)
        for (int n = 2; n <= 11; n++) begin
            load16(8'h36, 16'(n));
            if (n % 2 == 0) sweep_square("R8 even square wave", n);
            else            sweep_square("R9 odd square wave", n);
        end

        // R10: gate low forces high and restarts
        load16(8'h36, 16'd6);
        ticks(4);
        check("R10 low phase before gate", {31'd0, wave_out}, 32'd0);
        gate = 1'b0;
        @(negedge clk);
        check("R10 forced high", {31'd0, wave_out}, 32'd1);
        gate = 1'b1;
        @(negedge clk);
        sweep_square("R10 restart from reload", 6);

        // R11: latch command
        load16(8'h30, 16'h0150);
        ticks(3);
        put_ctrl(8'h00);
        ticks(5);
        put_ctrl(8'h00);
        get_byte(b);
        ticks(2);
        get_byte(b2);
        check("R11 frozen value", {16'd0, b2, b}, 32'h014D);
        read16(v);
        check("R11 live after reads", {16'd0, v}, 32'h0146);
        put_ctrl(8'h10);
        put_data(8'h20);
        ticks(2);
        put_ctrl(8'h00);
        ticks(3);
        get_byte(b);
        check("R11 single-byte frozen", {24'd0, b}, 32'h1E);
        get_byte(b);
        check("R11 single-byte released", {24'd0, b}, 32'h1B);

        // R13: decimal digits
        load16(8'h31, 16'h0100);
        ticks(1);
        read16(v);
        check("R13 decimal borrow", {16'd0, v}, 32'h0099);
        load16(8'h31, 16'h1000);
        ticks(1);
        read16(v);
        check("R13 decimal chain borrow", {16'd0, v}, 32'h0999);
        load16(8'h31, 16'h0050);
        ticks(3);
        read16(v);
        check("R13 decimal steps", {16'd0, v}, 32'h0047);
        load16(8'h37, 16'h0010);
        sweep_square("R13 decimal square period ten", 10);

        // R12: zero as the full span
        load16(8'h31, 16'h0000);
        ticks(1);
        read16(v);
        check("R12 decimal zero wraps", {16'd0, v}, 32'h9999);
        ticks(9998);
        check("R12 decimal low before span", {31'd0, wave_out}, 32'd0);
        ticks(1);
        check("R12 decimal high at span", {31'd0, wave_out}, 32'd1);
        load16(8'h30, 16'h0000);
        ticks(1);
        read16(v);
        check("R12 binary zero wraps", {16'd0, v}, 32'hFFFF);
        ticks(65534);
        check("R12 binary low before span", {31'd0, wave_out}, 32'd0);
        ticks(1);
        check("R12 binary high at span", {31'd0, wave_out}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule